// File: doc/BRIEF.md
# Cascadable Shift-Rotate Logic Unit

This block is the general logic stage of a byte-sliced micro-programmed datapath. Several source channels of full word width are merged onto one input bus. A short decoded micro-command then applies one operation to that bus value in a single cycle: pass-through, rotate, logical shift, complement, or increment. The result appears on the output bus in the same cycle. The default build uses four 8-bit slices, which gives a 32-bit word. Slice count, slice width and channel count are parameters.

A holding register, called the L register here, can capture the result at the clock edge. On the next micro-instruction the L register can be OR-ed back onto the input bus as an extra source. It is also the sole operand of increment, and the incrementer reports wrap-around through a carry flag. Shift and rotate distances run from 0 to 31. The direction is set by its own bit, and the whole move happens in one step through a logarithmic barrel network.

Top module: `shrot_logic_unit`

## Requirements
- R1: After reset the L register reads zero.
- R2: The input bus is the bitwise OR of all channels, plus the L register when `src_l_i` is 1.
- R3: With `op_i` = 0 (pass), or any unused code 5 to 7, `res_o` equals the input bus.
- R4: With `op_i` = 1 (rotate), the bus is rotated across the full word by `dist_i` positions. The rotation is toward the MSB when `dir_left_i` is 1 and toward the LSB when it is 0, and no bits are lost.
- R5: With `op_i` = 2 (logical shift), the bus moves by `dist_i` positions in the direction `dir_left_i` gives, and vacated positions fill with zero.
- R6: For rotate or shift, `dist_i` = 0 gives the unchanged bus.
- R7: With `op_i` = 3 (complement), `res_o` is the bitwise inverse of the bus.
- R8: With `op_i` = 4 (increment), `res_o` is the L register plus one modulo 2^W, and the bus has no effect. `carry_o` is 1 exactly when the L register is all ones, and in that case `res_o` is zero.
- R9: `carry_o` is 0 for every operation other than increment.
- R10: When `cap_l_i` is 1, the L register takes `res_o` at the clock edge. Otherwise it holds its value.
- R11: A captured value can be used in the very next cycle, either as a bus source or as the increment operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_i | input | CHANNELS*W | Source channels, channel k at bits [k*W +: W] |
| op_i | input | 3 | Operation code: 0 pass, 1 rotate, 2 shift, 3 complement, 4 increment |
| dist_i | input | 5 | Shift or rotate distance |
| dir_left_i | input | 1 | 1 moves toward the MSB, 0 toward the LSB |
| src_l_i | input | 1 | OR the L register onto the input bus |
| cap_l_i | input | 1 | Capture the result into the L register |
| res_o | output | W | Result bus |
| carry_o | output | 1 | Increment carry-out |
| lreg_o | output | W | Current L register value |

## Verification
The rotate assertion recomputes the bus as the OR of the channel inputs and the L register. It therefore assumes that channels feeding the unit are ones the controlling logic intends to merge, and that unselected sources drive zero. The bench keeps to this by making most channels zero in each random step and enabling only one to three of them. It drives each operation code with every distance and direction the random draw gives, and it adds directed runs at distances 0, 1 and 31 and at the all-ones increment wrap.

// File: rtl/lu_pkg.sv
package lu_pkg;
   typedef enum logic [2:0] {
      LU_PASS  = 3'd0,
      LU_ROT   = 3'd1,
      LU_SHIFT = 3'd2,
      LU_NOT   = 3'd3,
      LU_INC   = 3'd4
   } lu_op_e;
endpackage

// File: rtl/lu_bus_merge.sv
module lu_bus_merge #(
   parameter int CHANNELS = 9,
   parameter int W        = 32
) (
   input  logic [CHANNELS*W-1:0] chan_i,
   input  logic [W-1:0]          lreg_i,
   input  logic                  src_l_i,
   output logic [W-1:0]          bus_o
);
   logic [CHANNELS:0][W-1:0] acc;

   assign acc[0] = src_l_i ? lreg_i : '0;

   for (genvar k = 0; k < CHANNELS; k++) begin : g_or
      assign acc[k+1] = acc[k] | chan_i[k*W +: W];
   end

   assign bus_o = acc[CHANNELS];
endmodule

// File: rtl/lu_barrel.sv
module lu_barrel #(
   parameter int W    = 32,
   parameter int DW   = 5
) (
   input  logic [W-1:0]  a_i,
   input  logic [DW-1:0] dist_i,
   input  logic          left_i,
   input  logic          rotate_i,
   output logic [W-1:0]  y_o
);
   logic [DW:0][W-1:0] st;

   assign st[0] = a_i;

   for (genvar s = 0; s < DW; s++) begin : g_stage
      localparam int K  = 1 << s;
      localparam int KM = K % W;
      logic [2*W-1:0] dbl;
      logic [W-1:0]   rl, rr, sl, sr;

      assign dbl = {st[s], st[s]};
      assign rl  = dbl[2*W-1-KM -: W];
      assign rr  = dbl[KM +: W];

      if (K >= W) begin : g_flush
         assign sl = '0;
         assign sr = '0;
      end else begin : g_move
         assign sl = {st[s][W-1-K:0], {K{1'b0}}};
         assign sr = {{K{1'b0}}, st[s][W-1:K]};
      end

      assign st[s+1] = !dist_i[s] ? st[s] :
                       rotate_i   ? (left_i ? rl : rr) :
                                    (left_i ? sl : sr);
   end

   assign y_o = st[DW];
endmodule

// File: rtl/lu_incr.sv
module lu_incr #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   logic [W:0] ext;

   assign ext    = {1'b0, a_i} + {{W{1'b0}}, 1'b1};
   assign sum_o  = ext[W-1:0];
   assign cout_o = ext[W];
endmodule

// File: rtl/shrot_logic_unit.sv
module shrot_logic_unit #(
   parameter int SLICES   = 4,
   parameter int SLICE_W  = 8,
   parameter int CHANNELS = 9,
   parameter int DIST_W   = 5
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [CHANNELS*SLICES*SLICE_W-1:0] chan_i,
   input  logic [2:0]                         op_i,
   input  logic [DIST_W-1:0]                  dist_i,
   input  logic                               dir_left_i,
   input  logic                               src_l_i,
   input  logic                               cap_l_i,
   output logic [SLICES*SLICE_W-1:0]          res_o,
   output logic                               carry_o,
   output logic [SLICES*SLICE_W-1:0]          lreg_o
);
   import lu_pkg::*;

   localparam int W = SLICES * SLICE_W;

   if (SLICES < 1 || SLICES > 4) begin : g_bad_slices
      $error("shrot_logic_unit: SLICES must be 1 to 4");
   end
   if (CHANNELS < 1) begin : g_bad_chan
      $error("shrot_logic_unit: CHANNELS must be at least 1");
   end
   if (SLICE_W < 1 || DIST_W < 1) begin : g_bad_width
      $error("shrot_logic_unit: widths must be positive");
   end

   lu_op_e         op;
   logic [W-1:0]   bus, moved, inc_sum, lreg_q;
   logic           inc_cout;

   assign op = lu_op_e'(op_i);

   lu_bus_merge #(.CHANNELS(CHANNELS), .W(W)) u_merge (
      .chan_i (chan_i),
      .lreg_i (lreg_q),
      .src_l_i(src_l_i),
      .bus_o  (bus)
   );

   lu_barrel #(.W(W), .DW(DIST_W)) u_barrel (
      .a_i     (bus),
      .dist_i  (dist_i),
      .left_i  (dir_left_i),
      .rotate_i(op == LU_ROT),
      .y_o     (moved)
   );

   lu_incr #(.W(W)) u_incr (
      .a_i   (lreg_q),
      .sum_o (inc_sum),
      .cout_o(inc_cout)
   );

   always_comb begin
      res_o   = bus;
      carry_o = 1'b0;
      case (op)
         LU_ROT,
         LU_SHIFT: res_o = moved;
         LU_NOT:   res_o = ~bus;
         LU_INC: begin
            res_o   = inc_sum;
            carry_o = inc_cout;
         end
         default:  res_o = bus;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lreg_q <= '0;
      else if (cap_l_i) lreg_q <= res_o;
   end

   assign lreg_o = lreg_q;
endmodule

// File: rtl/lu_checker.sv
module lu_checker #(
   parameter int CHANNELS = 9,
   parameter int W        = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [CHANNELS*W-1:0] chan_i,
   input logic [2:0]            op_i,
   input logic                  src_l_i,
   input logic                  cap_l_i,
   input logic [W-1:0]          res_o,
   input logic                  carry_o,
   input logic [W-1:0]          lreg_o
);
   logic [W-1:0] seen_bus;

   always_comb begin
      seen_bus = src_l_i ? lreg_o : '0;
      for (int k = 0; k < CHANNELS; k++) seen_bus = seen_bus | chan_i[k*W +: W];
   end

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_l_i |=> $stable(lreg_o));

   a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap_l_i |=> lreg_o == $past(res_o));

   a_r9_carry_only_inc: assert property (@(posedge clk) disable iff (!rst_n)
      op_i != 3'd4 |-> !carry_o);

   a_r8_carry_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      carry_o |-> res_o == '0);

   a_r8_inc_value: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 3'd4 |-> res_o == W'(lreg_o + 1'b1));

   a_r4_rot_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 3'd1 |-> $countones(res_o) == $countones(seen_bus));

   a_r7_complement: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 3'd3 |-> res_o == ~seen_bus);
endmodule

bind shrot_logic_unit lu_checker #(.CHANNELS(CHANNELS), .W(W)) u_chk (.*);

// File: tb/tb_shrot_logic_unit.sv
module tb_shrot_logic_unit;
   localparam int W  = 32;
   localparam int CH = 9;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [CH*W-1:0] chan_i = '0;
   logic [2:0]      op_i = '0;
   logic [4:0]      dist_i = '0;
   logic            dir_left_i = 1'b0;
   logic            src_l_i = 1'b0;
   logic            cap_l_i = 1'b0;
   logic [W-1:0]    res_o, lreg_o;
   logic            carry_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [W-1:0] m_l = '0;

   always #2 clk = ~clk;

   shrot_logic_unit dut (.*);

   function automatic logic [W-1:0] f_bus(logic [CH*W-1:0] c, bit srcl, logic [W-1:0] l);
      logic [W-1:0] b = srcl ? l : '0;
      for (int k = 0; k < CH; k++) b |= c[k*W +: W];
      return b;
   endfunction

   function automatic logic [W-1:0] f_move(logic [W-1:0] b, int d, bit left, bit rot);
      logic [W-1:0] r = '0;
      for (int i = 0; i < W; i++) begin
         int j = left ? i + d : i - d;
         if (rot) r[(j + W) % W] = b[i];
         else if (j >= 0 && j < W) r[j] = b[i];
      end
      return r;
   endfunction

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(logic [CH*W-1:0] c, logic [2:0] op, int d, bit left, bit srcl, bit cap, string req);
      logic [W-1:0] b, e;
      bit ec;
      @(negedge clk);
      chan_i = c; op_i = op; dist_i = 5'(d); dir_left_i = left; src_l_i = srcl; cap_l_i = cap;
      #1;
      b  = f_bus(c, srcl, m_l);
      ec = 0;
      case (op)
         3'd1: e = f_move(b, d, left, 1);
         3'd2: e = f_move(b, d, left, 0);
         3'd3: e = ~b;
         3'd4: begin e = m_l + 1; ec = (m_l == '1); end
         default: e = b;
      endcase
      check(req, res_o, e);
      check("R9/R8 carry", {31'd0, carry_o}, {31'd0, ec});
      @(posedge clk);
      if (cap) m_l = e;
      #1;
      check("R10 L register", lreg_o, m_l);
   endtask

   function automatic logic [CH*W-1:0] one_chan(int k, logic [W-1:0] v);
      logic [CH*W-1:0] c = '0;
      c[k*W +: W] = v;
      return c;
   endfunction

   initial begin
      #100000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [CH*W-1:0] c;
      void'($urandom(32'd1234));
      #7;
      check("R1 reset L", lreg_o, '0);
      rst_n = 1'b1;
      // R3 pass and R2 OR merge of two channels
      step(one_chan(0, 32'hF0F0_0000) | one_chan(8, 32'h0000_0F0F), 3'd0, 0, 0, 0, 0, "R2 R3 merge pass");
      step(one_chan(3, 32'h1234_5678), 3'd6, 7, 1, 0, 0, "R3 unused code");
      // R6 distance zero
      step(one_chan(2, 32'hDEAD_BEEF), 3'd1, 0, 1, 0, 0, "R6 rotate zero");
      step(one_chan(2, 32'hDEAD_BEEF), 3'd2, 0, 0, 0, 0, "R6 shift zero");
      // R4 / R5 edges
      step(one_chan(1, 32'h8000_0001), 3'd1, 1, 1, 0, 0, "R4 rotl 1");
      step(one_chan(1, 32'h8000_0001), 3'd1, 31, 0, 0, 0, "R4 rotr 31");
      step(one_chan(1, 32'hFFFF_FFFF), 3'd2, 31, 1, 0, 0, "R5 shl 31");
      step(one_chan(1, 32'hFFFF_FFFF), 3'd2, 31, 0, 0, 0, "R5 shr 31");
      // R7 complement of zero, captured -> L all ones (R10)
      step('0, 3'd3, 0, 0, 0, 1, "R7 complement capture");
      // R8 wrap, bus ignored; R11 use right after capture
      step(one_chan(5, 32'h5555_5555), 3'd4, 3, 1, 0, 1, "R8 R11 inc wrap");
      step('0, 3'd4, 0, 0, 0, 1, "R8 inc from zero");
      step(one_chan(4, 32'h0000_0100), 3'd0, 0, 0, 1, 0, "R2 R11 L as source");
      // random
      for (int n = 0; n < 400; n++) begin
         int nch = 1 + ($urandom % 3);
         c = '0;
         for (int k = 0; k < nch; k++) c[($urandom % CH)*W +: W] |= $urandom;
         step(c, 3'($urandom % 8), int'($urandom % 32), bit'($urandom % 2),
              bit'($urandom % 2), bit'($urandom % 2), "R4 R5 R7 R8 random");
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule